// File: doc/BRIEF.md
# Real-Time Clock Second-Update Sequencer

This block keeps the seconds, minutes, hours and day-of-week of a real-time clock and runs the update that happens once per second. It counts enables from a 32.768 kHz timebase. At each second boundary it raises an update-in-progress status bit. A fixed number of timebase ticks later it advances the time, checks the new time against three alarm bytes, and pulses the alarm, update-ended and interrupt-request set lines to the flag register next to it. The time is presented as bytes in packed BCD or plain binary, with the hour in 12- or 24-hour form. Both choices are made at run time.

The host controls the block through plain configuration inputs. The freeze control halts the update sequence and lets the host load any time byte directly. A three-bit oscillator field must hold the run code, or no update happens and the second divider is held cleared. The time is kept inside the block in binary, and the output bytes are rendered from it in whatever format is selected at that moment.

Top module: `rtc_second_sequencer`

## Requirements
- R1: When `osc_sel` is not 3'b010, `uip_o` stays 0, the time bytes hold, and the second divider is cleared. The first boundary after the run code returns comes a full `TICKS_PER_SEC` ticks later.
- R2: While `cfg_freeze` is 1, `uip_o` is 0 (an open window is cancelled), the time bytes do not advance, and `alarm_set_o`, `update_set_o` and `irq_set_o` stay 0.
- R3: Every `TICKS_PER_SEC` enabled ticks, `uip_o` rises. It stays 1 for exactly `UIP_TICKS` further enabled ticks plus one clock. The time bytes do not change while `uip_o` is 1, and they take their new value at the same clock edge where `uip_o` falls.
- R4: When `cfg_binary` is 1, each byte is plain binary. When it is 0, each byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R5: When `cfg_h24` is 1, `hour_o` encodes 0 to 23. When it is 0, bits 6:0 encode the hour mod 12, and bit 7 is 1 for hours 12 to 23.
- R6: `alarm_set_o` is a one-clock pulse in the clock where the new time appears. It fires only if `cfg_alarm_en` is 1 and each of `alm_sec`, `alm_min` and `alm_hour` either equals the matching new byte or has bits 7:6 equal to 2'b11.
- R7: `update_set_o` pulses for one clock at each completed update when `cfg_upd_en` is 1. `irq_set_o` pulses whenever either `alarm_set_o` or `update_set_o` pulses.
- R8: Seconds and minutes roll over from 59 to 0, each carrying into the next field. Hours roll over from 23 to 0. Day-of-week goes from 7 to 1 on an hour carry.
- R9: While `cfg_freeze` is 1, a `wr_en` pulse loads `wr_data` into the field chosen by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 day-of-week). The data is read in the current number and hour format. With `cfg_freeze` at 0, writes are ignored. Counting resumes from the loaded time at the first boundary after freeze clears.
- R10: After reset, the time is 00:00:00 on day 1, and `uip_o`, `alarm_set_o`, `update_set_o` and `irq_set_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock enable at 32.768 kHz |
| osc_sel | input | 3 | Oscillator control field; 3'b010 runs |
| cfg_freeze | input | 1 | Halts updates and allows time loading |
| cfg_alarm_en | input | 1 | Enables the alarm set pulse |
| cfg_upd_en | input | 1 | Enables the update-ended set pulse |
| cfg_binary | input | 1 | 1 binary, 0 packed BCD |
| cfg_h24 | input | 1 | 1 24-hour, 0 12-hour with PM in bit 7 |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| wr_en | input | 1 | Host time-load strobe |
| wr_sel | input | 2 | Field selected for loading |
| wr_data | input | 8 | Byte to load |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day-of-week byte |
| uip_o | output | 1 | Update-in-progress status |
| alarm_set_o | output | 1 | Alarm flag set pulse |
| update_set_o | output | 1 | Update-ended flag set pulse |
| irq_set_o | output | 1 | Interrupt-request flag set pulse |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 16 and `UIP_TICKS` = 8, and asserts `tick_en` on every other clock. The short second fits dozens of updates into the run, so the carries from seconds through day-of-week appear many times. These include the hour wraps in both 12- and 24-hour form. The update window keeps its full length, so its tick count, and the time holding still during the window, are checked exactly.

// File: rtl/rtc_seq_pkg.sv
// Shared constants and format conversions for the second-update sequencer.
// Assumes the values passed in are already within range for their field.
package rtc_seq_pkg;

    localparam logic [2:0] OSC_RUN = 3'b010;

    typedef enum logic [1:0] {
        SEL_SEC  = 2'd0,
        SEL_MIN  = 2'd1,
        SEL_HOUR = 2'd2,
        SEL_DOW  = 2'd3
    } time_sel_e;

    // Encode a 0..99 value as binary or packed BCD.
    function automatic logic [7:0] enc_num(input logic [6:0] v, input logic bin);
        logic [3:0] tens, units;
        tens  = 4'(v / 7'd10);
        units = 4'(v % 7'd10);
        return bin ? {1'b0, v} : {tens, units};
    endfunction

    // Decode a binary or packed BCD byte into a plain value.
    function automatic logic [7:0] dec_num(input logic [7:0] b, input logic bin);
        return bin ? b : ({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
    endfunction

    // Encode an hour 0..23 in the selected number and hour form.
    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                            input logic h24);
        logic [7:0] r;
        logic       pm;
        pm = (h >= 5'd12);
        if (h24) begin
            r = enc_num({2'b00, h}, bin);
        end else begin
            r = enc_num({2'b00, pm ? h - 5'd12 : h}, bin);
            r[7] = pm;
        end
        return r;
    endfunction

    // Decode an hour byte into 0..23; out-of-range values fall back to 0.
    function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [7:0] v;
        if (h24) begin
            v = dec_num(b, bin);
        end else begin
            v = dec_num({1'b0, b[6:0]}, bin);
            if (v >= 8'd12) v = v - 8'd12;
            if (b[7]) v = v + 8'd12;
        end
        return (v > 8'd23) ? 5'd0 : v[4:0];
    endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
// Second divider and update-window sequencer.
// Counts tick_en pulses; at each wrap it opens the UIP window, and UIP_TICKS
// ticks later it issues a one-clock update strobe. The window closes on the
// edge after the strobe. Assumes UIP_TICKS < TICKS_PER_SEC.
module rtc_tick_divider #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic osc_ok,
    input  logic hold,
    output logic uip_o,
    output logic upd_o
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam int DW = $clog2(UIP_TICKS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(TICKS_PER_SEC - 1);
    localparam logic [DW-1:0] LAST_DLY = DW'(UIP_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] dly_q;
    logic          uip_q, upd_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST_CNT);

    // Divide the timebase, open/close the UIP window, strobe the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dly_q <= '0;
            uip_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (!osc_ok) begin
                cnt_q <= '0;
                dly_q <= '0;
                uip_q <= 1'b0;
            end else begin
                if (tick_en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
                if (upd_q) begin
                    uip_q <= 1'b0;
                end else if (uip_q && hold) begin
                    uip_q <= 1'b0;
                    dly_q <= '0;
                end else if (tick_en) begin
                    if (uip_q) begin
                        if (dly_q == LAST_DLY) begin
                            upd_q <= 1'b1;
                            dly_q <= '0;
                        end else begin
                            dly_q <= dly_q + 1'b1;
                        end
                    end else if (wrap && !hold) begin
                        uip_q <= 1'b1;
                        dly_q <= '0;
                    end
                end
            end
        end
    end

    assign uip_o = uip_q;
    assign upd_o = upd_q;

    AST_OSC_HALTS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ok |=> !uip_o); // R1
    AST_UPD_INSIDE_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> uip_o); // R3
    AST_UIP_FALLS_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !uip_o); // R3
endmodule

// File: rtl/rtc_time_core.sv
// Binary time registers with rollover and host loading.
// Holds seconds, minutes, hours (0..23) and day-of-week (1..7) in binary;
// advances on the update strobe, loads a decoded host byte on write.
module rtc_time_core
    import rtc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       load_en,
    input  logic [1:0] load_sel,
    input  logic [7:0] load_data,
    input  logic       cfg_binary,
    input  logic       cfg_h24,
    output logic [5:0] sec_q,
    output logic [5:0] min_q,
    output logic [4:0] hour_q,
    output logic [2:0] dow_q,
    output logic [5:0] nxt_sec,
    output logic [5:0] nxt_min,
    output logic [4:0] nxt_hour
);
    logic [2:0] nxt_dow;
    logic       s_wrap, m_wrap, h_wrap;
    logic [7:0] dv;
    logic [4:0] dh;

    // Next-second time with cascaded carries.
    always_comb begin
        s_wrap   = (sec_q >= 6'd59);
        m_wrap   = s_wrap && (min_q >= 6'd59);
        h_wrap   = m_wrap && (hour_q >= 5'd23);
        nxt_sec  = s_wrap ? 6'd0 : sec_q + 6'd1;
        nxt_min  = s_wrap ? ((min_q >= 6'd59) ? 6'd0 : min_q + 6'd1) : min_q;
        nxt_hour = m_wrap ? ((hour_q >= 5'd23) ? 5'd0 : hour_q + 5'd1) : hour_q;
        nxt_dow  = h_wrap ? ((dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1) : dow_q;
        dv       = dec_num(load_data, cfg_binary);
        dh       = dec_hour(load_data, cfg_binary, cfg_h24);
    end

    // Time registers: reset, host load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
            dow_q  <= 3'd1;
        end else if (load_en) begin
            unique case (time_sel_e'(load_sel))
                SEL_SEC:  sec_q  <= (dv > 8'd59) ? 6'd0 : dv[5:0];
                SEL_MIN:  min_q  <= (dv > 8'd59) ? 6'd0 : dv[5:0];
                SEL_HOUR: hour_q <= dh;
                SEL_DOW:  dow_q  <= (dv == 8'd0 || dv > 8'd7) ? 3'd1 : dv[2:0];
            endcase
        end else if (advance) begin
            sec_q  <= nxt_sec;
            min_q  <= nxt_min;
            hour_q <= nxt_hour;
            dow_q  <= nxt_dow;
        end
    end

    AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q < 6'd60 && min_q < 6'd60); // R8
    AST_HOUR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hour_q < 5'd24 && dow_q != 3'd0); // R8
endmodule

// File: rtl/rtc_fmt_render.sv
// Renders binary seconds, minutes and hours into output bytes in the
// selected number format and hour form. Purely combinational.
module rtc_fmt_render
    import rtc_seq_pkg::*;
(
    input  logic [5:0] sec,
    input  logic [5:0] min,
    input  logic [4:0] hour,
    input  logic       cfg_binary,
    input  logic       cfg_h24,
    output logic [7:0] sec_b,
    output logic [7:0] min_b,
    output logic [7:0] hour_b
);
    // Format each field.
    always_comb begin
        sec_b  = enc_num({1'b0, sec}, cfg_binary);
        min_b  = enc_num({1'b0, min}, cfg_binary);
        hour_b = enc_hour(hour, cfg_binary, cfg_h24);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Compares N alarm bytes against N time bytes; a byte with bits 7:6 = 2'b11
// matches anything. Output is 1 only if every byte matches.
module rtc_alarm_match #(
    parameter int N_FIELDS = 3
) (
    input  logic [N_FIELDS-1:0][7:0] alarm_b,
    input  logic [N_FIELDS-1:0][7:0] time_b,
    output logic                     match
);
    logic [N_FIELDS-1:0] hit;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        // Per-field exact or wildcard match.
        assign hit[i] = (alarm_b[i][7:6] == 2'b11) || (alarm_b[i] == time_b[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/rtc_second_sequencer.sv
// Once-per-second update sequencer of a real-time clock.
// Ties the divider, binary time core, format renderers and alarm matcher,
// and registers the flag set pulses in the clock the new time appears.
module rtc_second_sequencer
    import rtc_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] osc_sel,
    input  logic       cfg_freeze,
    input  logic       cfg_alarm_en,
    input  logic       cfg_upd_en,
    input  logic       cfg_binary,
    input  logic       cfg_h24,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic       uip_o,
    output logic       alarm_set_o,
    output logic       update_set_o,
    output logic       irq_set_o
);
    localparam int N_ALARM = 3;

    logic       upd, advance, match;
    logic [5:0] sec_q, min_q, nxt_sec, nxt_min;
    logic [4:0] hour_q, nxt_hour;
    logic [2:0] dow_q;
    logic [7:0] n_sec_b, n_min_b, n_hour_b;
    logic       alarm_q, updf_q;

    rtc_tick_divider #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .osc_ok (osc_sel == OSC_RUN),
        .hold   (cfg_freeze),
        .uip_o  (uip_o),
        .upd_o  (upd)
    );

    assign advance = upd && !cfg_freeze;

    rtc_time_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .load_en   (wr_en && cfg_freeze),
        .load_sel  (wr_sel),
        .load_data (wr_data),
        .cfg_binary(cfg_binary),
        .cfg_h24   (cfg_h24),
        .sec_q     (sec_q),
        .min_q     (min_q),
        .hour_q    (hour_q),
        .dow_q     (dow_q),
        .nxt_sec   (nxt_sec),
        .nxt_min   (nxt_min),
        .nxt_hour  (nxt_hour)
    );

    rtc_fmt_render u_cur_fmt (
        .sec(sec_q), .min(min_q), .hour(hour_q),
        .cfg_binary(cfg_binary), .cfg_h24(cfg_h24),
        .sec_b(sec_o), .min_b(min_o), .hour_b(hour_o)
    );

    rtc_fmt_render u_nxt_fmt (
        .sec(nxt_sec), .min(nxt_min), .hour(nxt_hour),
        .cfg_binary(cfg_binary), .cfg_h24(cfg_h24),
        .sec_b(n_sec_b), .min_b(n_min_b), .hour_b(n_hour_b)
    );

    assign dow_o = enc_num({4'd0, dow_q}, cfg_binary);

    rtc_alarm_match #(.N_FIELDS(N_ALARM)) u_alarm (
        .alarm_b({alm_hour, alm_min, alm_sec}),
        .time_b ({n_hour_b, n_min_b, n_sec_b}),
        .match  (match)
    );

    // Flag set pulses, registered with the time so both appear together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            updf_q  <= 1'b0;
        end else begin
            alarm_q <= advance && cfg_alarm_en && match;
            updf_q  <= advance && cfg_upd_en;
        end
    end

    assign alarm_set_o  = alarm_q;
    assign update_set_o = updf_q;
    assign irq_set_o    = alarm_q || updf_q;

    AST_FREEZE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_freeze |=> !alarm_set_o && !update_set_o); // R2
    AST_ALARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_set_o |-> $past(cfg_alarm_en)); // R6
    AST_UPD_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        update_set_o |-> $past(cfg_upd_en)); // R7
    AST_FLAG_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        update_set_o |=> !update_set_o); // R7
endmodule

// File: tb/tb_rtc_second_sequencer.sv
module tb_rtc_second_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 16;
    localparam int UIPT       = 8;

    logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic [2:0] osc_sel = 3'b010;
    logic       cfg_freeze = 0, cfg_alarm_en = 0, cfg_upd_en = 0;
    logic       cfg_binary = 0, cfg_h24 = 1;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic       wr_en = 0;
    logic [1:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] sec_o, min_o, hour_o, dow_o;
    logic       uip_o, alarm_set_o, update_set_o, irq_set_o;

    int n_chk = 0, n_bad = 0;
    int ms = 0, mm = 0, mh = 0, md = 1;  // model time, binary
    bit done = 0;

    rtc_second_sequencer #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_sel(osc_sel),
        .cfg_freeze(cfg_freeze), .cfg_alarm_en(cfg_alarm_en), .cfg_upd_en(cfg_upd_en),
        .cfg_binary(cfg_binary), .cfg_h24(cfg_h24),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .uip_o(uip_o), .alarm_set_o(alarm_set_o), .update_set_o(update_set_o),
        .irq_set_o(irq_set_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tick_en <= ~tick_en;  // enable every other clock

    function automatic logic [7:0] fnum(int v, bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] fhour(int h, bit bin, bit h24);
        logic [7:0] r;
        if (h24) return fnum(h, bin);
        r = fnum(h % 12, bin);
        r[7] = (h >= 12);
        return r;
    endfunction

    function automatic bit amatch(logic [7:0] a, logic [7:0] b);
        return (a[7:6] == 2'b11) || (a == b);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_time(string req);
        chk(sec_o == fnum(ms, cfg_binary), req, "sec", sec_o, fnum(ms, cfg_binary));
        chk(min_o == fnum(mm, cfg_binary), req, "min", min_o, fnum(mm, cfg_binary));
        chk(hour_o == fhour(mh, cfg_binary, cfg_h24), req, "hour", hour_o,
            fhour(mh, cfg_binary, cfg_h24));
        chk(dow_o == fnum(md, cfg_binary), req, "dow", dow_o, fnum(md, cfg_binary));
    endtask

    function automatic void next_time(inout int s, inout int m, inout int h, inout int d);
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin h = 0; d = (d == 7) ? 1 : d + 1; end
            end
        end
    endfunction

    // Load the model time into the DUT with freeze held (R9).
    task automatic load_time(int s, int m, int h, int d);
        @(negedge clk);
        cfg_freeze = 1;
        ms = s; mm = m; mh = h; md = d;
        for (int i = 0; i < 4; i++) begin
            wr_en = 1; wr_sel = 2'(i);
            wr_data = (i == 0) ? fnum(s, cfg_binary) : (i == 1) ? fnum(m, cfg_binary) :
                      (i == 2) ? fhour(h, cfg_binary, cfg_h24) : fnum(d, cfg_binary);
            @(negedge clk);
        end
        wr_en = 0;
        chk_time("R9");
        cfg_freeze = 0;
    endtask

    // Wait for one update and check window, time and flags (R3, R6, R7).
    task automatic do_second();
        int s = ms, m = mm, h = mh, d = md, ticks = 0, w = 0;
        bit held = 1, ea, eu;
        next_time(s, m, h, d);
        while (!uip_o && w < 4 * TPS + 20) begin @(negedge clk); w++; end
        chk(uip_o == 1, "R3", "uip rise", uip_o, 1);
        chk_time("R3");
        ea = cfg_alarm_en && amatch(alm_sec, fnum(s, cfg_binary)) &&
             amatch(alm_min, fnum(m, cfg_binary)) &&
             amatch(alm_hour, fhour(h, cfg_binary, cfg_h24));
        eu = cfg_upd_en;
        w = 0;
        while (uip_o && w < 4 * UIPT + 10) begin
            if (tick_en) ticks++;
            if (sec_o != fnum(ms, cfg_binary)) held = 0;
            @(negedge clk); w++;
        end
        chk(held, "R3", "time held in window", 0, 0);
        chk(ticks == UIPT, "R3", "window ticks", ticks, UIPT);
        ms = s; mm = m; mh = h; md = d;
        chk_time("R8");
        chk(alarm_set_o == ea, "R6", "alarm pulse", alarm_set_o, ea);
        chk(update_set_o == eu, "R7", "update pulse", update_set_o, eu);
        chk(irq_set_o == (ea || eu), "R7", "irq pulse", irq_set_o, ea || eu);
        @(negedge clk);
        chk(!alarm_set_o && !update_set_o && !irq_set_o, "R7", "pulse width",
            {alarm_set_o, update_set_o, irq_set_o}, 0);
    endtask

    // Hold a condition for several seconds and check nothing moves (R1, R2).
    task automatic quiet_check(string req);
        bit calm = 1;
        for (int i = 0; i < 3 * TPS * 2; i++) begin
            @(negedge clk);
            if (uip_o || alarm_set_o || update_set_o || irq_set_o ||
                sec_o != fnum(ms, cfg_binary)) calm = 0;
        end
        chk(calm, req, "no update while halted", 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R10 reset state
        chk_time("R10");
        chk(!uip_o && !alarm_set_o && !update_set_o && !irq_set_o, "R10", "status",
            {uip_o, alarm_set_o, update_set_o, irq_set_o}, 0);
        rst_n = 1;

        // R8 / R4 BCD 24h full carry chain
        cfg_upd_en = 1;
        load_time(58, 59, 23, 7);
        do_second();
        do_second();
        chk(dow_o == 8'h01 && hour_o == 8'h00, "R8", "day wrap", dow_o, 1);

        // R4 BCD digit placement
        load_time(38, 47, 19, 3);
        do_second();
        chk(sec_o == 8'h39, "R4", "bcd nibbles", sec_o, 8'h39);

        // R5 binary 12h: PM and midnight
        cfg_binary = 1; cfg_h24 = 0;
        load_time(59, 59, 23, 2);
        chk(hour_o == 8'h8B, "R5", "11 PM byte", hour_o, 8'h8B);
        do_second();
        chk(hour_o == 8'h00, "R5", "midnight byte", hour_o, 0);
        load_time(59, 59, 11, 2);
        do_second();
        chk(hour_o == 8'h80, "R5", "noon byte", hour_o, 8'h80);

        // R6 alarm: exact, wildcard, mismatch, disabled
        cfg_binary = 0; cfg_h24 = 1; cfg_upd_en = 0; cfg_alarm_en = 1;
        alm_sec = 8'h11; alm_min = 8'h22; alm_hour = 8'h05;
        load_time(10, 22, 5, 4);
        do_second();
        chk(alarm_set_o == 0 && sec_o == 8'h11, "R6", "exact match sec", sec_o, 8'h11);
        alm_sec = 8'hC0; alm_min = 8'hC5; alm_hour = 8'hFF;
        do_second();
        alm_sec = 8'h59;
        do_second();
        cfg_alarm_en = 0; alm_sec = 8'hC0;
        do_second();

        // R2 freeze halts everything
        cfg_upd_en = 1; cfg_alarm_en = 1;
        @(negedge clk); cfg_freeze = 1;
        quiet_check("R2");
        cfg_freeze = 0;
        do_second();

        // R1 oscillator not in run code
        @(negedge clk); osc_sel = 3'b110;
        quiet_check("R1");
        osc_sel = 3'b010;
        do_second();

        // R9 write ignored without freeze
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd0; wr_data = 8'h42;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        chk(sec_o == fnum(ms, cfg_binary), "R9", "write ignored", sec_o, fnum(ms, cfg_binary));
        do_second();

        // Random mix (R4, R5, R6, R7, R8)
        for (int it = 0; it < 30; it++) begin
            int s, m, h, d, ps, pm, ph, pd, sel;
            cfg_binary = 1'($urandom_range(0, 1));
            cfg_h24    = 1'($urandom_range(0, 1));
            cfg_alarm_en = 1'($urandom_range(0, 1));
            cfg_upd_en   = 1'($urandom_range(0, 1));
            s = $urandom_range(50, 59); m = $urandom_range(0, 59);
            if ($urandom_range(0, 1)) m = 59;
            h = $urandom_range(0, 23); d = $urandom_range(1, 7);
            ps = s; pm = m; ph = h; pd = d;
            next_time(ps, pm, ph, pd);
            sel = $urandom_range(0, 2);
            alm_sec  = (sel == 0) ? fnum(ps, cfg_binary) : (sel == 1) ? 8'hC3 : 8'(ps + 1);
            sel = $urandom_range(0, 2);
            alm_min  = (sel == 0) ? 8'hF0 : fnum(pm, cfg_binary);
            sel = $urandom_range(0, 2);
            alm_hour = (sel == 0) ? 8'hC0 : fhour(ph, cfg_binary, cfg_h24);
            load_time(s, m, h, d);
            do_second();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule